// File: doc/BRIEF.md
# Bit-Parallel NFA Pattern Matcher

This block scans a byte stream against one regular expression that has already been compiled into a nondeterministic automaton of up to `N` states. Each state stands for one character class, and a state can only become active on a byte that its class admits. The block keeps the whole set of live states as one bit vector and moves it forward one byte per clock. Each step is two wide bitwise operations and nothing else. The first is a union of the successor rows of every live state, with the start states added in. The second masks that union with the acceptance vector of the incoming byte.

Software loads the automaton through a write-only configuration port before matching starts. It writes the successor rows, one acceptance vector per byte value, the start-state vector and the mask of final states. The start states are added on every byte, so a match may begin anywhere in the stream. For every byte consumed, the block raises a match flag on the following cycle when any final state is live. It also exposes the live-state vector directly.

Top module: `nfa_bitvec_matcher`

## Requirements
- R1: After reset, `state_vec` is all zeros, `match` is low and `in_ready` is high. The start vector, the final-state mask and all successor rows read as zero until they are written.
- R2: A byte consumed while `state_vec` = V makes the next `state_vec` equal to (S OR Q) AND A[byte]. S is the OR of successor row i over every bit i set in V, Q is the start vector, and A[b] is the acceptance vector stored for byte value b. Bit j of successor row i set means state j may follow state i.
- R3: Q is added on every consumed byte, so a match can start at any stream position, including after bytes that left no live state.
- R4: `match` is high in the cycle after a consumed byte exactly when the new `state_vec` AND the final-state mask is nonzero. It is low in any cycle that follows a cycle with no consumed byte.
- R5: While `clear` is high, `in_ready` is low and no byte is consumed. On the next cycle `state_vec` is all zeros and `match` is low.
- R6: While `cfg_we` is high, `in_ready` is low and no byte is consumed. A byte is consumed only in a cycle where `in_valid` and `in_ready` are both high. In any other cycle without `clear`, `state_vec` holds its value.
- R7: Configuration writes use `cfg_sel`: 0 writes successor row `cfg_addr` (ignored when `cfg_addr` >= N), 1 writes the acceptance vector for byte value `cfg_addr`, 2 writes the start vector, and 3 writes the final-state mask. In every case the value is `cfg_data`.
- R8: A consumed byte whose acceptance vector is zero empties `state_vec` and gives `match` low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Empties the live-state vector |
| in_valid | input | 1 | Stream byte is present |
| in_byte | input | 8 | Stream byte |
| in_ready | output | 1 | Block can take a byte this cycle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target select |
| cfg_addr | input | 8 | Row index or byte value |
| cfg_data | input | N | Value written |
| match | output | 1 | A final state was live after the last byte |
| state_vec | output | N | Live-state vector |

## Verification
The live-state vector is a port, so any wrong bit in it is visible in the cycle after the byte that produced it. It is checked against an independent bit-vector model on every byte. A fault in a successor row or acceptance entry stays hidden until a live state selects that row or that byte value arrives. For that reason the stream tests use a real regular-expression automaton with long bytes sequences and also random tables. A fault in the match path shows on `match` one cycle after the byte. Handshake and clear faults show up as a `state_vec` change in a cycle that should have held the value or emptied it.

// File: rtl/nfa_bitvec_matcher.sv
module nfa_bitvec_matcher #(
  parameter int N     = 8,
  parameter int BYTES = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         in_valid,
  input  logic [7:0]   in_byte,
  output logic         in_ready,
  input  logic         cfg_we,
  input  logic [1:0]   cfg_sel,
  input  logic [7:0]   cfg_addr,
  input  logic [N-1:0] cfg_data,
  output logic         match,
  output logic [N-1:0] state_vec
);
  localparam int AW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0] succ [N];
  logic [N-1:0] accept_tab [BYTES];
  logic [N-1:0] start_q, final_q, live_q;
  logic [N-1:0] succ_union, accept_row, next_live;
  logic         match_q, fire;

  assign in_ready  = ~cfg_we & ~clear;
  assign fire      = in_valid & in_ready;
  assign accept_row = accept_tab[in_byte];

  always_comb begin
    succ_union = '0;
    for (int i = 0; i < N; i++)
      if (live_q[i]) succ_union = succ_union | succ[i];
  end

  assign next_live = (succ_union | start_q) & accept_row;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      final_q <= '0;
      for (int i = 0; i < N; i++) succ[i] <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0: if (int'(cfg_addr) < N) succ[cfg_addr[AW-1:0]] <= cfg_data;
        2'd2: start_q <= cfg_data;
        2'd3: final_q <= cfg_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (cfg_we && cfg_sel == 2'd1) accept_tab[cfg_addr] <= cfg_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      live_q  <= '0;
      match_q <= 1'b0;
    end else if (fire) begin
      live_q  <= next_live;
      match_q <= |(next_live & final_q);
    end else begin
      match_q <= 1'b0;
    end
  end

  assign state_vec = live_q;
  assign match     = match_q;

  // R5
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (state_vec == '0 && !match));

  // R6
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && in_ready) && !clear) |=> $stable(state_vec));

  // R4
  no_match_without_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> !match);

  // R4
  match_needs_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> (state_vec != '0));

  // R2
  live_within_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ((state_vec & ~$past(accept_row)) == '0));
endmodule

// File: tb/nfa_bitvec_matcher_bench.sv
module nfa_bitvec_matcher_bench;
  localparam int N = 8;

  logic         clk = 0, rst_n = 0, clear = 0, in_valid = 0, cfg_we = 0;
  logic [7:0]   in_byte = 0, cfg_addr = 0;
  logic [1:0]   cfg_sel = 0;
  logic [N-1:0] cfg_data = 0;
  logic         in_ready, match;
  logic [N-1:0] state_vec;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [N-1:0] m_succ [N];
  logic [N-1:0] m_acc [256];
  logic [N-1:0] m_q, m_fin, m_v;

  always #4 clk = ~clk;

  nfa_bitvec_matcher #(.N(N)) u_nfa_bitvec_matcher (
    .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid),
    .in_byte(in_byte), .in_ready(in_ready), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .match(match), .state_vec(state_vec));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] m_next(input logic [N-1:0] v, input logic [7:0] b);
    logic [N-1:0] u = '0;
    for (int i = 0; i < N; i++) if (v[i]) u |= m_succ[i];
    return (u | m_q) & m_acc[b];
  endfunction

  task automatic cfg(input logic [1:0] sel, input int addr, input logic [N-1:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_addr = addr[7:0]; cfg_data = d;
    if (sel == 0 && addr < N) m_succ[addr] = d;
    if (sel == 1) m_acc[addr] = d;
    if (sel == 2) m_q = d;
    if (sel == 3) m_fin = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // Drives one byte at a negedge and checks the outputs at the next negedge.
  task automatic send(input logic [7:0] b, input string req);
    logic [N-1:0] e;
    @(negedge clk);
    in_valid = 1; in_byte = b;
    e = m_next(m_v, b);
    @(negedge clk);
    in_valid = 0;
    m_v = e;
    chk(state_vec == e, req, state_vec, e);
    chk(match == |(e & m_fin), req, match, |(e & m_fin));
  endtask

  task automatic load_regex;
    // states: 0 '/', 1 'f', 2 'n', 3 's', 4 not-CR/LF, 5 'i', 6 '&', 7 unused
    logic [N-1:0] a;
    cfg(0, 0, 8'b0111_1010);
    cfg(0, 1, 8'b0000_0100);
    cfg(0, 2, 8'b0111_0000);
    cfg(0, 3, 8'b0111_0000);
    cfg(0, 4, 8'b0111_0000);
    cfg(0, 5, 8'b0000_0000);
    cfg(0, 6, 8'b0100_0000);
    cfg(0, 7, 8'b0000_0000);
    for (int b = 0; b < 256; b++) begin
      a = '0;
      if (b != 8'h0d && b != 8'h0a) a[4] = 1;
      if (b == "/") a[0] = 1;
      if (b == "f") a[1] = 1;
      if (b == "n") a[2] = 1;
      if (b == "s") a[3] = 1;
      if (b == "i") a[5] = 1;
      if (b == "&") a[6] = 1;
      cfg(1, b, a);
    end
    cfg(2, 0, 8'b0000_0001);
    cfg(3, 0, 8'b0111_1101);
  endtask

  task automatic do_clear;
    @(negedge clk);
    clear = 1; in_valid = 1; in_byte = "/";
    @(negedge clk);
    clear = 0; in_valid = 0;
    m_v = '0;
  endtask

  task automatic t_reset;
    chk(state_vec == '0, "R1 state", state_vec, 0);
    chk(match == 0, "R1 match", match, 0);
    chk(in_ready == 1, "R1 ready", in_ready, 1);
    for (int i = 0; i < N; i++) m_succ[i] = '0;
    m_q = '0; m_fin = '0; m_v = '0;
    cfg(1, 8'h41, 8'hff);
    send(8'h41, "R1 empty start vector");
  endtask

  task automatic t_reference;
    string s = "/fn?ssi";
    load_regex();
    do_clear();
    send("/", "R2 first byte");
    chk(state_vec == 8'h01, "R2 hand value", state_vec, 8'h01);
    for (int i = 1; i < s.len(); i++) send(s[i], "R2 reference stream");
  endtask

  task automatic t_any_start;
    do_clear();
    send("x", "R3 no live state");
    chk(state_vec == 8'h00, "R3 empty", state_vec, 0);
    send("x", "R3 still empty");
    send("/", "R3 late start");
    chk(match == 1, "R3 match at late start", match, 1);
  endtask

  task automatic t_zero_accept;
    do_clear();
    send("/", "R8 setup");
    send("a", "R8 setup");
    send(8'h0a, "R8 zero acceptance");
    chk(state_vec == '0 && match == 0, "R8 emptied", state_vec, 0);
  endtask

  task automatic t_match_timing;
    do_clear();
    send("/", "R4 match after byte");
    @(negedge clk);
    chk(match == 0, "R4 idle cycle", match, 0);
    chk(state_vec == m_v, "R6 hold idle", state_vec, m_v);
  endtask

  task automatic t_stall;
    logic [N-1:0] keep;
    do_clear();
    send("/", "R6 setup");
    keep = m_v;
    @(negedge clk);
    in_valid = 1; in_byte = "f"; cfg_we = 1; cfg_sel = 3; cfg_data = m_fin;
    #1 chk(in_ready == 0, "R6 ready low on cfg", in_ready, 0);
    @(negedge clk);
    cfg_we = 0; in_valid = 0;
    chk(state_vec == keep, "R6 byte ignored during cfg", state_vec, keep);
    chk(match == 0, "R6 no match", match, 0);
    @(negedge clk);
    clear = 1;
    #1 chk(in_ready == 0, "R5 ready low on clear", in_ready, 0);
    @(negedge clk);
    clear = 0; m_v = '0;
    chk(state_vec == '0 && match == 0, "R5 cleared", state_vec, 0);
  endtask

  task automatic t_cfg_select;
    do_clear();
    cfg(0, 9, 8'hff);
    send("/", "R7 row beyond N ignored");
    send("f", "R7 row beyond N ignored");
    cfg(3, 0, 8'b0000_0010);
    do_clear();
    send("/", "R7 new final mask");
    send("f", "R7 new final mask");
    chk(match == 1, "R7 f is final", match, 1);
  endtask

  task automatic t_random_regex_input;
    string alpha = "/fnsi&x?\n";
    load_regex();
    do_clear();
    for (int k = 0; k < 300; k++)
      send(alpha[$urandom_range(0, alpha.len() - 1)], "R2 random stream");
  endtask

  task automatic t_random_tables;
    for (int i = 0; i < N; i++) cfg(0, i, N'($urandom));
    for (int b = 0; b < 256; b++) cfg(1, b, N'($urandom));
    cfg(2, 0, N'($urandom) | 8'h01);
    cfg(3, 0, N'($urandom));
    do_clear();
    for (int k = 0; k < 300; k++) send(8'($urandom), "R2 random tables");
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_reference();
    t_any_start();
    t_zero_accept();
    t_match_timing();
    t_stall();
    t_cfg_select();
    t_random_regex_input();
    t_random_tables();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule